// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets an external SPI master reach a bank of sixteen-bit registers. The registers themselves sit outside the block, next to the PWM logic. The slave works in SPI mode 0, most significant bit first. Chip select, clock and data are brought into the system clock domain through synchronisers, and both clock edges are detected there. Every frame opens with a command byte; only its two top bits are decoded, as `{bit7, bit6}`: `01` is write, `10` is read, `11` is status and `00` does nothing.

A write frame carries five bytes: the command, a 16-bit address (high byte first) and a 16-bit data word (high byte first). If address bit 15 is set, the data word goes to the register selected by address bits 14..0 through a one-cycle write strobe. If address bit 15 is clear, the frame only stores the address for a later read, and its data bytes are discarded. A read frame sends a single command byte. While the master clocks four more bytes, the slave returns two zero bytes and then the register at the stored address, high byte first. A status frame has the same shape but returns a fixed identification word. The register bank holds `NUM_REGS` entries; addresses past the bank are not written and read back as zero.

Top module: `spi_regif`

## Requirements
- R1: A frame with write command (`{bit7,bit6}`=`01`, bits 5..0 of any value) and address bit 15 set raises `reg_we` for exactly one system clock. `reg_waddr` then carries address bits 4..0 and `reg_wdata` carries the 16-bit data, whose first-sent byte is bits 15..8.
- R2: A write-command frame whose address has bit 15 clear raises no `reg_we` and stores the address for reads. A write frame with bit 15 set leaves the stored address unchanged.
- R3: A read command (`{bit7,bit6}`=`10`) returns on MISO two 0x00 bytes and then the register at the stored address, high byte first. The first bit appears after the falling SCLK edge that follows the command byte's last rising edge.
- R4: A status command (`{bit7,bit6}`=`11`) returns two 0x00 bytes and then `ID_VALUE`, high byte first.
- R5: When address bits 14..5 are not all zero (for the default of 32 registers), a write raises no `reg_we`, and a read of such a stored address returns 0x0000.
- R6: A frame ended by chip select rising before its fifth byte is complete raises no `reg_we`. The next frame is decoded from its first byte again, even if the abort came in the middle of a byte.
- R7: Bytes clocked after the fifth byte of a frame have no effect: no further `reg_we` is raised.
- R8: MISO is 0 while chip select is high and during the command byte of every frame.
- R9: After reset, `reg_we` and MISO are 0.
- R10: A command byte with both top bits clear raises no `reg_we`, does not change the stored address, and returns only zero bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_sclk | input | 1 | SPI clock from the master, idle low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_cs_n | input | 1 | Active-low chip select; a rising edge ends the frame |
| spi_miso | output | 1 | Serial data to the master |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_waddr | output | ADDR_W | Register write address |
| reg_wdata | output | 16 | Register write data |
| reg_raddr | output | ADDR_W | Register read address (the stored address) |
| reg_rdata | input | 16 | Register read data for `reg_raddr`, same cycle |

## Verification
The bench uses the default parameters: 32 registers, a two-stage synchroniser and the default identification word. The SCLK half period is eight system clocks. With 32 registers, the last mapped address (31) and the first unmapped one (32) both sit in a short stimulus list, and so do a far address with high bits set. The slow SCLK leaves room for the synchroniser delay, so each MISO bit can be sampled just before the master's rising edge.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int RESP_W = 2 * WORD_W;

  // Command kind, decoded from command bits {7,6}
  typedef enum logic [1:0] {
    CMD_NONE   = 2'b00,
    CMD_WRITE  = 2'b01,
    CMD_READ   = 2'b10,
    CMD_STATUS = 2'b11
  } cmd_e;

  // Position of the next byte within a frame
  typedef enum logic [2:0] {
    SLOT_CMD,
    SLOT_ADDR_HI,
    SLOT_ADDR_LO,
    SLOT_DATA_HI,
    SLOT_DATA_LO,
    SLOT_TAIL
  } slot_e;

endpackage

// File: rtl/spi_regif_sync.sv
module spi_regif_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
    end else begin
      chain_q[0] <= d_in;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/spi_regif_shift.sv
module spi_regif_shift
  import spi_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic              cs_idle,
  input  logic              tx_load,
  input  logic [RESP_W-1:0] tx_word,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              miso
);

  logic              sclk_d;
  logic [2:0]        bit_cnt_q, bit_cnt_d;
  logic [BYTE_W-2:0] rx_sr_q, rx_sr_d;
  logic [RESP_W-1:0] tx_sr_q, tx_sr_d;
  logic              miso_q, miso_d;
  logic              done_q, done_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              rise, fall;

  assign rise = sclk_s & ~sclk_d;
  assign fall = ~sclk_s & sclk_d;

  always_comb begin
    bit_cnt_d = bit_cnt_q;
    rx_sr_d   = rx_sr_q;
    tx_sr_d   = tx_sr_q;
    miso_d    = miso_q;
    done_d    = 1'b0;
    byte_d    = byte_q;
    if (cs_idle) begin
      bit_cnt_d = '0;
      tx_sr_d   = '0;
      miso_d    = 1'b0;
    end else begin
      if (rise) begin
        rx_sr_d   = {rx_sr_q[BYTE_W-3:0], mosi_s};
        bit_cnt_d = bit_cnt_q + 3'd1;
        if (bit_cnt_q == 3'd7) begin
          done_d = 1'b1;
          byte_d = {rx_sr_q, mosi_s};
        end
      end
      if (fall) begin
        miso_d  = tx_sr_q[RESP_W-1];
        tx_sr_d = {tx_sr_q[RESP_W-2:0], 1'b0};
      end
      if (tx_load) tx_sr_d = tx_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d    <= 1'b0;
      bit_cnt_q <= '0;
      rx_sr_q   <= '0;
      tx_sr_q   <= '0;
      miso_q    <= 1'b0;
      done_q    <= 1'b0;
      byte_q    <= '0;
    end else begin
      sclk_d    <= sclk_s;
      bit_cnt_q <= bit_cnt_d;
      rx_sr_q   <= rx_sr_d;
      tx_sr_q   <= tx_sr_d;
      miso_q    <= miso_d;
      done_q    <= done_d;
      byte_q    <= byte_d;
    end
  end

  assign byte_done = done_q;
  assign rx_byte   = byte_q;
  assign miso      = miso_q;

  // R8: output stays low across an idle chip select
  assert_idle_miso_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_idle && $past(cs_idle)) |-> !miso);

  // R6: an ended frame restarts bit counting
  assert_bit_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> (bit_cnt_q == 3'd0));

endmodule

// File: rtl/spi_regif_frame.sv
module spi_regif_frame
  import spi_regif_pkg::*;
#(
  parameter int              NUM_REGS = 32,
  parameter logic [WORD_W-1:0] ID_VALUE = 16'hC35A,
  localparam int             ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_idle,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [WORD_W-1:0] reg_rdata,
  output logic              tx_load,
  output logic [RESP_W-1:0] tx_word,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_waddr,
  output logic [WORD_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_raddr
);

  slot_e             slot_q, slot_d;
  cmd_e              cmd_q, cmd_d;
  logic [WORD_W-1:0] addr_q, addr_d;
  logic [BYTE_W-1:0] dhi_q, dhi_d;
  logic [WORD_W-2:0] lat_q, lat_d;
  logic              we_q, we_d;
  logic [ADDR_W-1:0] waddr_q, waddr_d;
  logic [WORD_W-1:0] wdata_q, wdata_d;
  logic              addr_hit, lat_hit;

  assign addr_hit = (addr_q[WORD_W-2:ADDR_W] == '0);
  assign lat_hit  = (lat_q[WORD_W-2:ADDR_W] == '0);

  always_comb begin
    slot_d  = slot_q;
    cmd_d   = cmd_q;
    addr_d  = addr_q;
    dhi_d   = dhi_q;
    lat_d   = lat_q;
    we_d    = 1'b0;
    waddr_d = waddr_q;
    wdata_d = wdata_q;
    if (cs_idle) begin
      slot_d = SLOT_CMD;
    end else if (byte_done) begin
      unique case (slot_q)
        SLOT_CMD: begin
          cmd_d  = cmd_e'(rx_byte[7:6]);
          slot_d = SLOT_ADDR_HI;
        end
        SLOT_ADDR_HI: begin
          addr_d[WORD_W-1:BYTE_W] = rx_byte;
          slot_d = SLOT_ADDR_LO;
        end
        SLOT_ADDR_LO: begin
          addr_d[BYTE_W-1:0] = rx_byte;
          if (cmd_q == CMD_WRITE && !addr_q[WORD_W-1])
            lat_d = {addr_q[WORD_W-2:BYTE_W], rx_byte};
          slot_d = SLOT_DATA_HI;
        end
        SLOT_DATA_HI: begin
          dhi_d  = rx_byte;
          slot_d = SLOT_DATA_LO;
        end
        SLOT_DATA_LO: begin
          if (cmd_q == CMD_WRITE && addr_q[WORD_W-1] && addr_hit) begin
            we_d    = 1'b1;
            waddr_d = addr_q[ADDR_W-1:0];
            wdata_d = {dhi_q, rx_byte};
          end
          slot_d = SLOT_TAIL;
        end
        default: slot_d = SLOT_TAIL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= SLOT_CMD;
      cmd_q   <= CMD_NONE;
      addr_q  <= '0;
      dhi_q   <= '0;
      lat_q   <= '0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      slot_q  <= slot_d;
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
      dhi_q   <= dhi_d;
      lat_q   <= lat_d;
      we_q    <= we_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
    end
  end

  // Response is loaded once the command byte ends with its read flag set
  assign tx_load = !cs_idle && byte_done && (slot_q == SLOT_CMD) && rx_byte[7];
  assign tx_word = rx_byte[6] ? {{WORD_W{1'b0}}, ID_VALUE}
                              : {{WORD_W{1'b0}}, (lat_hit ? reg_rdata : {WORD_W{1'b0}})};

  assign reg_we    = we_q;
  assign reg_waddr = waddr_q;
  assign reg_wdata = wdata_q;
  assign reg_raddr = lat_q[ADDR_W-1:0];

  // R1: a commit lasts exactly one cycle
  assert_we_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R6: a commit only follows bytes received inside an open frame
  assert_we_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(!cs_idle));

  // R2: a committing frame leaves the read address alone
  assert_latch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $stable(lat_q));

endmodule

// File: rtl/spi_regif.sv
module spi_regif
  import spi_regif_pkg::*;
#(
  parameter int                NUM_REGS    = 32,
  parameter logic [WORD_W-1:0] ID_VALUE    = 16'hC35A,
  parameter int                SYNC_STAGES = 2,
  localparam int               ADDR_W      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  input  logic              spi_cs_n,
  output logic              spi_miso,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_waddr,
  output logic [WORD_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_raddr,
  input  logic [WORD_W-1:0] reg_rdata
);

  logic [1:0]        rst_pipe_q;
  logic              rst_n_int;
  logic [2:0]        pins_s;
  logic              byte_done, tx_load;
  logic [BYTE_W-1:0] rx_byte;
  logic [RESP_W-1:0] tx_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  // pins_s = {cs_n, mosi, sclk}
  spi_regif_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) i_sync (
    .clk  (clk),
    .rst_n(rst_n_int),
    .d_in ({spi_cs_n, spi_mosi, spi_sclk}),
    .d_out(pins_s)
  );

  spi_regif_shift i_shift (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .sclk_s   (pins_s[0]),
    .mosi_s   (pins_s[1]),
    .cs_idle  (pins_s[2]),
    .tx_load  (tx_load),
    .tx_word  (tx_word),
    .byte_done(byte_done),
    .rx_byte  (rx_byte),
    .miso     (spi_miso)
  );

  spi_regif_frame #(
    .NUM_REGS(NUM_REGS),
    .ID_VALUE(ID_VALUE)
  ) i_frame (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .cs_idle  (pins_s[2]),
    .byte_done(byte_done),
    .rx_byte  (rx_byte),
    .reg_rdata(reg_rdata),
    .tx_load  (tx_load),
    .tx_word  (tx_word),
    .reg_we   (reg_we),
    .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr)
  );

endmodule

// File: tb/test_spi_regif.sv
module test_spi_regif;

  localparam int NREG = 32;
  localparam logic [15:0] ID = 16'hC35A;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic cs_n = 1'b1;
  logic miso;
  logic reg_we;
  logic [4:0] reg_waddr;
  logic [15:0] reg_wdata;
  logic [4:0] reg_raddr;
  logic [15:0] reg_rdata;

  logic [15:0] rf [NREG];
  logic [15:0] exp_rf [NREG];
  logic [14:0] exp_lat;
  logic [20:0] wq [$];
  logic [7:0] tx_buf [8];
  logic [7:0] rx_buf [8];
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  spi_regif #(.NUM_REGS(NREG), .ID_VALUE(ID), .SYNC_STAGES(2)) i_spi_regif (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_cs_n(cs_n),
    .spi_miso(miso), .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata));

  // Register store on the far side of the write/read ports
  always @(posedge clk) if (reg_we) rf[reg_waddr] <= reg_wdata;
  assign reg_rdata = rf[reg_raddr];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: every write strobe must match the next expected item
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      if (wq.size() == 0) chk("R2/R5/R6/R7/R10 unexpected write", {11'd0, reg_waddr, reg_wdata}, 32'hFFFFFFFF);
      else chk("R1 write port", {11'd0, reg_waddr, reg_wdata}, {11'd0, wq.pop_front()});
    end
  end

  task automatic run_frame(input int n);
    @(negedge clk) cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      for (int i = 7; i >= 0; i--) begin
        mosi = tx_buf[k][i];
        repeat (H) @(negedge clk);
        rx_buf[k][i] = miso;
        sclk = 1'b1;
        repeat (H) @(negedge clk);
        sclk = 1'b0;
      end
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (4 * H) @(negedge clk);
  endtask

  task automatic wr_frame(input logic [7:0] cmd, input logic [15:0] a, input logic [15:0] d, input int n);
    if (cmd[7:6] == 2'b01 && n >= 5) begin
      if (a[15] && a[14:5] == 0) begin
        wq.push_back({a[4:0], d});
        exp_rf[a[4:0]] = d;
      end else if (!a[15]) exp_lat = a[14:0];
    end
    tx_buf[0] = cmd; tx_buf[1] = a[15:8]; tx_buf[2] = a[7:0];
    tx_buf[3] = d[15:8]; tx_buf[4] = d[7:0]; tx_buf[5] = 8'hA5; tx_buf[6] = 8'h3C; tx_buf[7] = 8'h00;
    run_frame(n);
  endtask

  task automatic rd_frame(input logic [7:0] cmd, input logic [15:0] exp, input string tag);
    tx_buf[0] = cmd;
    for (int k = 1; k < 5; k++) tx_buf[k] = 8'h00;
    run_frame(5);
    chk({tag, " / R8 command byte"}, {24'd0, rx_buf[0]}, 32'd0);
    chk(tag, {rx_buf[1], rx_buf[2], rx_buf[3], rx_buf[4]}, {16'd0, exp});
  endtask

  function automatic logic [15:0] exp_read();
    return (exp_lat[14:5] == 0) ? exp_rf[exp_lat[4:0]] : 16'h0000;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) begin rf[i] = 16'h0000; exp_rf[i] = 16'h0000; end
    exp_lat = '0;
    repeat (5) @(negedge clk);
    chk("R9 reset we", {31'd0, reg_we}, 32'd0);
    chk("R9 reset miso", {31'd0, miso}, 32'd0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R9 after release miso", {31'd0, miso}, 32'd0);

    // R1: plain writes, top address, reserved command bits set
    wr_frame(8'h40, 16'h8003, 16'h1234, 5);
    wr_frame(8'h40, 16'h801F, 16'hBEEF, 5);
    wr_frame(8'h7F, 16'h8000, 16'h0F0F, 5);
    // R2 + R3: latch then fetch
    wr_frame(8'h40, 16'h0003, 16'hFFFF, 5);
    rd_frame(8'h80, exp_read(), "R3 read reg 3");
    rd_frame(8'hBF, exp_read(), "R3 repeat read, reserved bits");
    wr_frame(8'h40, 16'h001F, 16'h0000, 5);
    rd_frame(8'h80, exp_read(), "R3 read reg 31");
    wr_frame(8'h40, 16'h0000, 16'h1111, 5);
    rd_frame(8'h80, exp_read(), "R3 read reg 0");
    // R2: a committing write keeps the stored address
    wr_frame(8'h40, 16'h0003, 16'h0000, 5);
    wr_frame(8'h40, 16'h8007, 16'h7777, 5);
    rd_frame(8'h80, exp_read(), "R2 latch kept over write");
    chk("R2 latched value", {16'd0, exp_read()}, 32'h00001234);
    // R4 status
    rd_frame(8'hC0, ID, "R4 status");
    rd_frame(8'hFF, ID, "R4 status reserved bits");
    // R5 out of range
    wr_frame(8'h40, 16'h8020, 16'hAAAA, 5);
    wr_frame(8'h40, 16'h0020, 16'h0000, 5);
    rd_frame(8'h80, 16'h0000, "R5 read addr 32");
    wr_frame(8'h40, 16'h7FFF, 16'h0000, 5);
    rd_frame(8'h80, 16'h0000, "R5 read addr 7FFF");
    // R6 aborted frames
    wr_frame(8'h40, 16'h8005, 16'h5555, 4);
    tx_buf[0] = 8'h40; tx_buf[1] = 8'h80;
    @(negedge clk) cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 7; i >= 3; i--) begin
      mosi = tx_buf[0][i];
      repeat (H) @(negedge clk); sclk = 1'b1;
      repeat (H) @(negedge clk); sclk = 1'b0;
    end
    repeat (H) @(negedge clk); cs_n = 1'b1;
    repeat (4 * H) @(negedge clk);
    wr_frame(8'h40, 16'h8005, 16'h6666, 5);
    wr_frame(8'h40, 16'h0005, 16'h0000, 5);
    rd_frame(8'h80, exp_read(), "R6 resync after abort");
    chk("R6 reg 5 value", {16'd0, exp_read()}, 32'h00006666);
    // R7 long frame: bytes 6 and 7 ignored
    wr_frame(8'h40, 16'h8009, 16'h9A9A, 7);
    wr_frame(8'h40, 16'h0009, 16'h0000, 5);
    rd_frame(8'h80, exp_read(), "R7 long frame single write");
    // R10 null command
    wr_frame(8'h00, 16'h8009, 16'h1111, 5);
    for (int k = 0; k < 5; k++) chk("R10 null response", {24'd0, rx_buf[k]}, 32'd0);
    wr_frame(8'h00, 16'h0003, 16'h0000, 5);
    rd_frame(8'h80, exp_read(), "R10 latch untouched");
    // R8 idle line
    repeat (20) @(negedge clk);
    chk("R8 idle miso", {31'd0, miso}, 32'd0);
    chk("R1 all expected writes seen", wq.size(), 32'd0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule